// File: doc/BRIEF.md
# Shunt Compensator Reference Current Generator

This block produces the three per-phase current references for a four-wire shunt compensator. It handles one control sample at a time. Each sample carries three signed load-current readings, three unit-amplitude synchronising sinusoids from an external phase tracker, and three per-phase loss-conductance corrections.

The block first projects the load currents onto the sinusoids and normalises the result by the nominal sinusoid power. This gives an instantaneous conductance. A moving average over one full window of samples turns it into an average conductance. Each phase then adds its own loss term to the common average to form a control conductance. That control conductance, times the phase sinusoid, is the wanted active current. The reference is that active current minus the measured load current. Every narrowing step clips instead of wrapping.

Number formats: load currents and references are signed integers of `IW` bits. Sinusoids are signed `SW`-bit values with `SF` fraction bits, so 16384 means 1.0 by default. Conductances are signed `GW`-bit values with `GF` fraction bits.

Top module: `shunt_iref_gen`

## Requirements
- R1: While `rstN` is low and after it is released, `outValid` is 0 and every reference output is 0. The averaging history and its running sum start from zero, so the first average after reset is the first instantaneous conductance divided by the window length.
- R2: A sample is accepted when `inValid` is 1 while the block is idle. `outValid` is then 1 for exactly one cycle, on the sixth rising edge after the accepting edge. The reference outputs change only on that edge and hold their values until the next result.
- R3: `inValid` during the five cycles after an accepting edge is ignored. It produces no extra result and changes neither the captured operands nor the averaging history.
- R4: The projection is P = Σ iLoad·pll, summed over the three phases. The instantaneous conductance is (P·K) >>> (RF+SF−GF), clipped to `GW` bits. Here K = ⌊(2^(RF+SF) + S/2)/S⌋ and S = `SUMSQ_Q`, the nominal sum of squared sinusoids, which is 24576 (1.5) by default. With the defaults, RF=16, SF=14 and GF=8.
- R5: The average conductance is (Σ·M) >>> AF, clipped to `GW` bits. Σ is the sum of the last `WIN` instantaneous values, with zeros counted for samples not yet seen since reset, and M = ⌊(2^AF + WIN/2)/WIN⌋.
- R6: The control conductance of phase p is the average conductance plus `gLoss` of phase p, clipped to the signed `GW`-bit range.
- R7: The reference of phase p is ((gCtl_p · pll_p) >>> (GF+SF)) − iLoad_p.
- R8: The reference of R7 is clipped to the signed `IW`-bit range, −32768 to 32767 by default, and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | New sample present on the data inputs |
| iLoadA | input | IW | Phase A load current, signed |
| iLoadB | input | IW | Phase B load current, signed |
| iLoadC | input | IW | Phase C load current, signed |
| pllA | input | SW | Phase A synchronising sinusoid, signed, SF fraction bits |
| pllB | input | SW | Phase B synchronising sinusoid |
| pllC | input | SW | Phase C synchronising sinusoid |
| gLossA | input | GW | Phase A loss conductance, signed, GF fraction bits |
| gLossB | input | GW | Phase B loss conductance |
| gLossC | input | GW | Phase C loss conductance |
| outValid | output | 1 | One-cycle pulse marking new references |
| iRefA | output | IW | Phase A reference current |
| iRefB | output | IW | Phase B reference current |
| iRefC | output | IW | Phase C reference current |

## Verification
- **Load in phase, varying amplitude:** a load in phase with the sinusoids, with its amplitude changed over more than one window, separates a correct running-sum eviction from a plain accumulator.
- **Load in quadrature:** a load in quadrature with the sinusoids must project to zero conductance. This catches a wrong phase pairing in the projection.
- **Distinct loss terms:** different loss terms on each phase show that the control conductances stay independent.
- **Extreme values:** full-scale loss terms and load currents at the range limits drive the conductance and reference clipping from both sides.
- **Pulses while busy:** extra `inValid` pulses with different data, sent while a sample is in flight, must leave both the result and the history untouched.

// File: rtl/iref_pkg.sv
package iref_pkg;

  localparam int NPH = 3;

  typedef struct packed {
    logic ldIn;
    logic doNorm;
    logic doAvg;
    logic doMean;
    logic doCtl;
    logic doRef;
  } stb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NORM,
    ST_AVG,
    ST_MEAN,
    ST_CTL,
    ST_REF
  } state_t;

  // Clip a wide signed value into the signed range of w bits
  function automatic longint satClip(input longint v, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - longint'(1);
    lo = -hi - longint'(1);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/iref_ctrl.sv
module iref_ctrl
  import iref_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  output stb_t stb,
  output logic outValid
);

  state_t state;
  state_t stateNxt;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (inValid) begin
          stb.ldIn = 1'b1;
          stateNxt = ST_NORM;
        end
      end
      ST_NORM: begin
        stb.doNorm = 1'b1;
        stateNxt   = ST_AVG;
      end
      ST_AVG: begin
        stb.doAvg = 1'b1;
        stateNxt  = ST_MEAN;
      end
      ST_MEAN: begin
        stb.doMean = 1'b1;
        stateNxt   = ST_CTL;
      end
      ST_CTL: begin
        stb.doCtl = 1'b1;
        stateNxt  = ST_REF;
      end
      ST_REF: begin
        stb.doRef = 1'b1;
        stateNxt  = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      outValid <= 1'b0;
    end else begin
      state    <= stateNxt;
      outValid <= stb.doRef;
    end
  end

  // R2
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && inValid) |-> ##6 outValid);

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

endmodule

// File: rtl/iref_datapath.sv
module iref_datapath
  import iref_pkg::*;
#(
  parameter int IW         = 16,
  parameter int SW         = 16,
  parameter int SF         = 14,
  parameter int GW         = 24,
  parameter int GF         = 8,
  parameter int WIN        = 640,
  parameter int RF         = 16,
  parameter int AF         = 24,
  parameter int SUMSQ_Q    = 24576,
  parameter bit NORM_RECIP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  stb_t              stb,
  input  logic signed [IW-1:0] iLoad [NPH],
  input  logic signed [SW-1:0] pll   [NPH],
  input  logic signed [GW-1:0] gLoss [NPH],
  output logic signed [IW-1:0] iRef  [NPH]
);

  localparam int     PROJ_W = IW + SW + 2;
  localparam int     PTR_W  = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int     SUM_W  = GW + PTR_W + 1;
  localparam longint AVG_M  = ((longint'(1) <<< AF) + longint'(WIN / 2)) / longint'(WIN);

  // Stage 1: capture operands and form the projection
  logic signed [IW-1:0]     ilR   [NPH];
  logic signed [SW-1:0]     pllR  [NPH];
  logic signed [GW-1:0]     lossR [NPH];
  logic signed [PROJ_W-1:0] projR;
  logic signed [PROJ_W-1:0] projNxt;
  longint                   projAcc;

  always_comb begin
    projAcc = 0;
    for (int p = 0; p < NPH; p++) begin
      projAcc = projAcc + longint'(iLoad[p]) * longint'(pll[p]);
    end
    projNxt = projAcc[PROJ_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      projR <= '0;
      for (int p = 0; p < NPH; p++) begin
        ilR[p]   <= '0;
        pllR[p]  <= '0;
        lossR[p] <= '0;
      end
    end else if (stb.ldIn) begin
      projR <= projNxt;
      for (int p = 0; p < NPH; p++) begin
        ilR[p]   <= iLoad[p];
        pllR[p]  <= pll[p];
        lossR[p] <= gLoss[p];
      end
    end
  end

  // Stage 2: normalise the projection into an instantaneous conductance
  logic signed [GW-1:0] gInst;
  logic signed [GW-1:0] gInstNxt;

  if (NORM_RECIP) begin : g_recip
    localparam longint RECIP =
      ((longint'(1) <<< (RF + SF)) + longint'(SUMSQ_Q / 2)) / longint'(SUMSQ_Q);
    longint scaled;
    longint clipped;
    always_comb begin
      scaled   = (longint'(projR) * RECIP) >>> (RF + SF - GF);
      clipped  = satClip(scaled, GW);
      gInstNxt = clipped[GW-1:0];
    end
  end else begin : g_raw
    longint scaled;
    longint clipped;
    always_comb begin
      scaled   = longint'(projR) >>> (SF - GF);
      clipped  = satClip(scaled, GW);
      gInstNxt = clipped[GW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           gInst <= '0;
    else if (stb.doNorm) gInst <= gInstNxt;
  end

  // Stage 3: sliding window history and running sum
  logic signed [GW-1:0]    winMem [WIN];
  logic [PTR_W-1:0]        wrPtr;
  logic signed [SUM_W-1:0] winSum;
  logic signed [SUM_W-1:0] winSumNxt;
  longint                  sumWide;

  always_comb begin
    sumWide   = longint'(winSum) + longint'(gInst) - longint'(winMem[wrPtr]);
    winSumNxt = sumWide[SUM_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winSum <= '0;
      wrPtr  <= '0;
      for (int k = 0; k < WIN; k++) winMem[k] <= '0;
    end else if (stb.doAvg) begin
      winSum        <= winSumNxt;
      winMem[wrPtr] <= gInst;
      wrPtr         <= (wrPtr == PTR_W'(WIN - 1)) ? '0 : wrPtr + 1'b1;
    end
  end

  // Stage 4: average conductance by reciprocal of window length
  logic signed [GW-1:0] gBar;
  logic signed [GW-1:0] gBarNxt;
  longint               meanWide;

  always_comb begin
    meanWide = satClip((longint'(winSum) * AVG_M) >>> AF, GW);
    gBarNxt  = meanWide[GW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           gBar <= '0;
    else if (stb.doMean) gBar <= gBarNxt;
  end

  // Stages 5 and 6: per-phase control conductance and reference
  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic signed [GW-1:0] gCtlR;
    logic signed [IW-1:0] refR;
    longint ctlWide;
    longint actWide;
    longint refWide;

    always_comb begin
      ctlWide = satClip(longint'(gBar) + longint'(lossR[p]), GW);
      actWide = (longint'(gCtlR) * longint'(pllR[p])) >>> (GF + SF);
      refWide = satClip(actWide - longint'(ilR[p]), IW);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gCtlR <= '0;
        refR  <= '0;
      end else begin
        if (stb.doCtl) gCtlR <= ctlWide[GW-1:0];
        if (stb.doRef) refR  <= refWide[IW-1:0];
      end
    end

    assign iRef[p] = refR;
  end

  // R2
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.doRef |=> ($stable(iRef[0]) && $stable(iRef[1]) && $stable(iRef[2])));

  // R3
  input_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldIn |=> ($stable(ilR[0]) && $stable(pllR[1]) && $stable(lossR[2]) && $stable(projR)));

  // R5
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.doAvg |=> ($stable(winSum) && $stable(wrPtr)));

endmodule

// File: rtl/shunt_iref_gen.sv
module shunt_iref_gen
  import iref_pkg::*;
#(
  parameter int IW         = 16,
  parameter int SW         = 16,
  parameter int SF         = 14,
  parameter int GW         = 24,
  parameter int GF         = 8,
  parameter int WIN        = 640,
  parameter int RF         = 16,
  parameter int AF         = 24,
  parameter int SUMSQ_Q    = 24576,
  parameter bit NORM_RECIP = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic signed [IW-1:0] iLoadA,
  input  logic signed [IW-1:0] iLoadB,
  input  logic signed [IW-1:0] iLoadC,
  input  logic signed [SW-1:0] pllA,
  input  logic signed [SW-1:0] pllB,
  input  logic signed [SW-1:0] pllC,
  input  logic signed [GW-1:0] gLossA,
  input  logic signed [GW-1:0] gLossB,
  input  logic signed [GW-1:0] gLossC,
  output logic                 outValid,
  output logic signed [IW-1:0] iRefA,
  output logic signed [IW-1:0] iRefB,
  output logic signed [IW-1:0] iRefC
);

  stb_t                 stb;
  logic signed [IW-1:0] iLoadArr [NPH];
  logic signed [SW-1:0] pllArr   [NPH];
  logic signed [GW-1:0] gLossArr [NPH];
  logic signed [IW-1:0] iRefArr  [NPH];

  assign iLoadArr[0] = iLoadA;
  assign iLoadArr[1] = iLoadB;
  assign iLoadArr[2] = iLoadC;
  assign pllArr[0]   = pllA;
  assign pllArr[1]   = pllB;
  assign pllArr[2]   = pllC;
  assign gLossArr[0] = gLossA;
  assign gLossArr[1] = gLossB;
  assign gLossArr[2] = gLossC;
  assign iRefA       = iRefArr[0];
  assign iRefB       = iRefArr[1];
  assign iRefC       = iRefArr[2];

  iref_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  iref_datapath #(
    .IW         (IW),
    .SW         (SW),
    .SF         (SF),
    .GW         (GW),
    .GF         (GF),
    .WIN        (WIN),
    .RF         (RF),
    .AF         (AF),
    .SUMSQ_Q    (SUMSQ_Q),
    .NORM_RECIP (NORM_RECIP)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .iLoad (iLoadArr),
    .pll   (pllArr),
    .gLoss (gLossArr),
    .iRef  (iRefArr)
  );

endmodule

// File: tb/shunt_iref_gen_bench.sv
module shunt_iref_gen_bench;

  localparam int IW = 16, SW = 16, SF = 14, GW = 24, GF = 8;
  localparam int WIN = 8, RF = 16, AF = 24, SUMSQ_Q = 24576;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [IW-1:0] iLoadA = '0, iLoadB = '0, iLoadC = '0;
  logic signed [SW-1:0] pllA = '0, pllB = '0, pllC = '0;
  logic signed [GW-1:0] gLossA = '0, gLossB = '0, gLossC = '0;
  logic outValid;
  logic signed [IW-1:0] iRefA, iRefB, iRefC;

  always #4 clk = ~clk;

  shunt_iref_gen #(.WIN(WIN)) u_shunt_iref_gen (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .iLoadA(iLoadA), .iLoadB(iLoadB), .iLoadC(iLoadC),
    .pllA(pllA), .pllB(pllB), .pllC(pllC),
    .gLossA(gLossA), .gLossB(gLossB), .gLossC(gLossC),
    .outValid(outValid), .iRefA(iRefA), .iRefB(iRefB), .iRefC(iRefC)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Independent model state
  longint histM [WIN];
  int     histPtr = 0;
  longint sumM = 0;
  longint recipK;
  longint avgM;

  function automatic longint clip(input longint v, input int w);
    longint hi;
    hi = (longint'(1) <<< (w - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Drive one sample, check latency (R2) and the three references.
  // busyPoke: keep inValid high with other data during the busy cycles (R3).
  task automatic runSample(input longint la, input longint lb, input longint lc,
                           input longint pa, input longint pb, input longint pc,
                           input longint sa, input longint sb, input longint sc,
                           input string tag, input bit busyPoke);
    longint il[3], pl[3], ls[3], er[3], proj, gi, gb, gc, act;
    bit early;
    il = '{la, lb, lc}; pl = '{pa, pb, pc}; ls = '{sa, sb, sc};
    proj = la * pa + lb * pb + lc * pc;
    gi = clip((proj * recipK) >>> (RF + SF - GF), GW);          // R4
    sumM = sumM + gi - histM[histPtr];                            // R5
    histM[histPtr] = gi;
    histPtr = (histPtr + 1) % WIN;
    gb = clip((sumM * avgM) >>> AF, GW);
    for (int p = 0; p < 3; p++) begin
      gc = clip(gb + ls[p], GW);                                  // R6
      act = (gc * pl[p]) >>> (GF + SF);                           // R7
      er[p] = clip(act - il[p], IW);                              // R8
    end
    @(negedge clk);
    iLoadA = la[IW-1:0]; iLoadB = lb[IW-1:0]; iLoadC = lc[IW-1:0];
    pllA = pa[SW-1:0]; pllB = pb[SW-1:0]; pllC = pc[SW-1:0];
    gLossA = sa[GW-1:0]; gLossB = sb[GW-1:0]; gLossC = sc[GW-1:0];
    inValid = 1'b1;
    early = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 1) begin
        if (busyPoke) begin
          iLoadA = 16'sd12345; iLoadB = -16'sd9999; iLoadC = 16'sd777;
          pllA = -16'sd16384; pllB = 16'sd4000; pllC = 16'sd100;
          gLossA = 24'sd400000; gLossB = 24'sd5; gLossC = -24'sd70000;
        end else begin
          inValid = 1'b0;
        end
      end
      if (k == 3) inValid = 1'b0;
      if (k < 6 && outValid) early = 1'b1;
    end
    check(!early && outValid, "R2", {tag, " outValid on sixth edge only"},
          longint'(outValid), 1);
    check(longint'(iRefA) == er[0], {tag, "/R7"}, "iRefA", longint'(iRefA), er[0]);
    check(longint'(iRefB) == er[1], {tag, "/R7"}, "iRefB", longint'(iRefB), er[1]);
    check(longint'(iRefC) == er[2], {tag, "/R7"}, "iRefC", longint'(iRefC), er[2]);
    @(negedge clk);
    check(!outValid, "R2", {tag, " outValid single cycle"}, longint'(outValid), 0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(!outValid, "R1", "outValid in reset", longint'(outValid), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!outValid, "R1", "outValid after reset", longint'(outValid), 0);
    check(iRefA == 0, "R1", "iRefA after reset", longint'(iRefA), 0);
    check(iRefB == 0, "R1", "iRefB after reset", longint'(iRefB), 0);
    check(iRefC == 0, "R1", "iRefC after reset", longint'(iRefC), 0);
  endtask

  // R1 / R4: first sample sees a cleared history, load in phase
  task automatic testInPhase();
    runSample(1000, -500, -500, 16384, -8192, -8192, 0, 0, 0, "R1 R4 inphase", 1'b0);
  endtask

  // R5: amplitude ramp over more than one window exercises eviction
  task automatic testWindow();
    for (int n = 0; n < 11; n++) begin
      runSample(200 * n, -100 * n, -100 * n, 16384, -8192, -8192, 0, 0, 0,
                "R5 window", 1'b0);
    end
  endtask

  // R4: load in quadrature projects to zero
  task automatic testQuadrature();
    runSample(0, 866, -866, 16384, -8192, -8192, 0, 0, 0, "R4 quadrature", 1'b0);
    runSample(1200, -600, -600, 0, 14189, -14189, 0, 0, 0, "R4 quadrature90", 1'b0);
  endtask

  // R6: each phase has its own loss term
  task automatic testLoss();
    runSample(800, -400, -400, 16384, -8192, -8192, 2560, -1280, 0, "R6 perphase", 1'b0);
    runSample(800, -400, -400, 16384, -8192, -8192, 8388607, -8388608, 0,
              "R6 ctlclip", 1'b0);
  endtask

  // R8: references clip at both ends
  task automatic testSaturate();
    runSample(-32768, 32767, 0, 16384, 16384, 0, 8388607, -8388608, 0,
              "R8 refclip", 1'b0);
  endtask

  // R3: inValid while busy is ignored; no extra result follows
  task automatic testIgnore();
    bit extra;
    runSample(700, -350, -350, 16384, -8192, -8192, 100, 200, 300, "R3 busyignore", 1'b1);
    extra = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (outValid) extra = 1'b1;
    end
    check(!extra, "R3", "no extra result from busy pulses", longint'(extra), 0);
    // history untouched: next result still matches the model
    runSample(700, -350, -350, 16384, -8192, -8192, 0, 0, 0, "R3 after", 1'b0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    for (int k = 0; k < WIN; k++) histM[k] = 0;
    recipK = ((longint'(1) <<< (RF + SF)) + SUMSQ_Q / 2) / SUMSQ_Q;
    avgM = ((longint'(1) <<< AF) + WIN / 2) / WIN;
    testReset();
    testInPhase();
    testWindow();
    testQuadrature();
    testLoss();
    testSaturate();
    testIgnore();
    finishRun();
  end

endmodule